// File: doc/BRIEF.md
# Dual-Byte GPIO Port with Edge Interrupts

This block serves two general-purpose I/O ports of up to eight lines each from one register bank. Software reaches it over a small request/ready bus with two byte enables. Each register can be accessed one byte at a time, with the low byte holding the lower port and the high byte holding the upper port. It can also be accessed as one 16-bit half-word. The block drives the pad output values, the output enables and the pull controls. It brings each pad input through a two-flop synchronizer before the input register and the edge detectors see it.

Every line can raise an interrupt flag on a rising or a falling edge. Each port has its own interrupt request line and its own encoded vector register. The vector names the lowest-numbered pending pin that is enabled, and reading it clears that pin's flag. The upper port is built with `HI_PINS` lines, six by default. Its missing lines ignore writes and never raise flags.

The bus front end is a two-state machine. In `BUS_IDLE`, an asserted `bus_sel` performs the access on that clock edge and moves the machine to `BUS_RESP` (transition *accept*). `BUS_RESP` drives `bus_ready` and the read data for one cycle, then returns to `BUS_IDLE` unconditionally (transition *complete*). While the machine is in `BUS_RESP`, `bus_sel` is ignored.

Top module: `gpio_pair_irq`

Register addresses (`bus_addr`): 0 input, 1 output, 2 direction, 3 pull enable, 4 edge select, 5 interrupt enable, 6 flags, 7 low-port vector, 8 high-port vector. All other addresses read as zero.

## Requirements
- R1: A 1 in direction bit i drives `pad_oe[i]` high. Output bit i appears on `pad_out[i]` whatever the direction.
- R2: Address 0 returns the pad inputs after two synchronizing flops. Writes to address 0 change nothing.
- R3: `pad_pull_en[i]` is high only when pull bit i is set and direction bit i is 0. `pad_pull_up[i]` is then equal to output bit i, so 1 selects pull-up and 0 selects pull-down.
- R4: `bus_be[0]` selects the low byte (lower port) and `bus_be[1]` selects the high byte (upper port). A write with both enables updates all 16 bits, and a write with one enable leaves the other byte unchanged.
- R5: Edge-select bit 0 flags a rising edge and bit 1 flags a falling edge. A detected edge sets the pin's flag even when its interrupt enable is 0.
- R6: `irq[0]` (lower port) and `irq[1]` (upper port) are high exactly while some flag of that port has its enable bit set.
- R7: A vector reads 0 when its port has no enabled pending flag. Otherwise it reads 2*(i+1) for the lowest such pin i, so pin 0 wins.
- R8: Reading a vector clears only the flag it reported.
- R9: The vectors sit at separate addresses 7 and 8 and are returned in the low byte with the high byte zero. No 16-bit vector exists.
- R10: Writing the flag register sets and clears flags directly.
- R11: Upper-port bits at or above `HI_PINS` ignore writes, read as 0 and never set a flag or raise `irq[1]`.
- R12: Changing an edge-select bit while its pin is steady does not set a flag.
- R13: An access is taken on the first edge where `bus_sel` is high in `BUS_IDLE`. `bus_ready` is high for exactly the following cycle, and `bus_rdata` is valid then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 4 | Register address |
| bus_be | input | 2 | Byte enables, bit 0 low byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with ready |
| bus_ready | output | 1 | Access completed |
| pad_in | input | 16 | Raw pad inputs |
| pad_out | output | 16 | Pad output values |
| pad_oe | output | 16 | Pad output enables |
| pad_pull_en | output | 16 | Pull resistor enables |
| pad_pull_up | output | 16 | Pull direction, 1 up |
| irq | output | 2 | Per-port interrupt request |

## Verification
A flag that is stuck or set wrongly shows up on `irq` in the cycle after the register write or the third cycle after the pad change. It also shows up as a wrong vector code on the next vector read. A fault in the byte-lane steering shows up on `pad_out` or `pad_oe` one cycle after the write, because those pins mirror the registers directly. A fault in the synchronizer or the edge detectors shows up as a wrong input value or a missing flag, read back four cycles after the pad changes. A state-machine fault shows up at once as a missing or stretched `bus_ready`.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [3:0] {
        REG_IN     = 4'd0,
        REG_OUT    = 4'd1,
        REG_DIR    = 4'd2,
        REG_PULL   = 4'd3,
        REG_EDGE   = 4'd4,
        REG_IE     = 4'd5,
        REG_FLAG   = 4'd6,
        REG_VEC_LO = 4'd7,
        REG_VEC_HI = 4'd8
    } reg_idx_t;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_t;

    // vector code of the lowest set bit, 0 when none
    function automatic logic [7:0] vec_code(input logic [7:0] p);
        logic [7:0] v;
        v = 8'd0;
        for (int i = 7; i >= 0; i--) begin
            if (p[i]) v = 8'(2 * (i + 1));
        end
        return v;
    endfunction

    // one-hot of the lowest set bit
    function automatic logic [7:0] lowest_bit(input logic [7:0] p);
        logic [7:0] v;
        v = 8'd0;
        for (int i = 7; i >= 0; i--) begin
            if (p[i]) v = 8'(1 << i);
        end
        return v;
    endfunction

    function automatic logic [7:0] pin_mask(input int pins);
        return (pins >= 8) ? 8'hFF : 8'((1 << pins) - 1);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    output logic take,
    output logic ready
);
    bus_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        ready   = 1'b0;
        unique case (state_q)
            BUS_IDLE: begin
                take = sel;
                if (sel) state_d = BUS_RESP;   // accept
            end
            BUS_RESP: begin
                ready   = 1'b1;
                state_d = BUS_IDLE;            // complete
            end
        endcase
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] pin_sync,
    input  logic       wr_en,
    input  reg_idx_t   wr_sel,
    input  logic [7:0] wdata,
    input  logic       vec_clr,
    output logic [7:0] in_q,
    output logic [7:0] out_q,
    output logic [7:0] dir_q,
    output logic [7:0] pull_q,
    output logic [7:0] edge_q,
    output logic [7:0] ie_q,
    output logic [7:0] flag_q,
    output logic [7:0] vec,
    output logic       irq
);
    localparam logic [7:0] MASK = pin_mask(PINS);

    logic [7:0] prev_q;
    logic [7:0] rise, fall, hit, pending, clr_bit, flag_d;
    logic [7:0] wmask;

    assign wmask = wdata & MASK;
    assign in_q  = pin_sync & MASK;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= in_q;
    end

    // edge detection compares samples, never the select bit
    assign rise = in_q & ~prev_q;
    assign fall = ~in_q & prev_q;
    assign hit  = ((rise & ~edge_q) | (fall & edge_q)) & MASK;

    assign pending = flag_q & ie_q;
    assign clr_bit = lowest_bit(pending);
    assign vec     = vec_code(pending);
    assign irq     = |pending;

    always_comb begin
        flag_d = flag_q;
        if (wr_en && wr_sel == REG_FLAG) flag_d = wmask;
        else if (vec_clr)                flag_d = flag_q & ~clr_bit;
        flag_d = (flag_d | hit) & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            pull_q <= '0;
            edge_q <= '0;
            ie_q   <= '0;
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
            if (wr_en) begin
                case (wr_sel)
                    REG_OUT:  out_q  <= wmask;
                    REG_DIR:  dir_q  <= wmask;
                    REG_PULL: pull_q <= wmask;
                    REG_EDGE: edge_q <= wmask;
                    REG_IE:   ie_q   <= wmask;
                    default:  ;
                endcase
            end
        end
    end
endmodule

// File: rtl/gpio_pair_irq.sv
module gpio_pair_irq
    import gpio_pkg::*;
#(
    parameter int LO_PINS     = 8,
    parameter int HI_PINS     = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [1:0]  bus_be,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        bus_ready,
    input  logic [15:0] pad_in,
    output logic [15:0] pad_out,
    output logic [15:0] pad_oe,
    output logic [15:0] pad_pull_en,
    output logic [15:0] pad_pull_up,
    output logic [1:0]  irq
);
    localparam int NPORT = 2;

    logic        take;
    logic [15:0] pin_sync;
    logic [15:0] rdata_q;
    reg_idx_t    sel_reg;

    logic [7:0] in_b   [NPORT];
    logic [7:0] out_b  [NPORT];
    logic [7:0] dir_b  [NPORT];
    logic [7:0] pull_b [NPORT];
    logic [7:0] edge_b [NPORT];
    logic [7:0] ie_b   [NPORT];
    logic [7:0] flag_b [NPORT];
    logic [7:0] vec_b  [NPORT];
    logic [NPORT-1:0] irq_b;
    logic [7:0] hi_flag_q;

    assign sel_reg = reg_idx_t'(bus_addr);

    gpio_bus_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (bus_sel),
        .take  (take),
        .ready (bus_ready)
    );

    gpio_sync #(.W(16), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_sync)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam int PINS_P = (p == 0) ? LO_PINS : HI_PINS;
        localparam reg_idx_t VEC_REG = (p == 0) ? REG_VEC_LO : REG_VEC_HI;
        logic wr_en_p, vec_clr_p;
        assign wr_en_p   = take && bus_wr && bus_be[p];
        assign vec_clr_p = take && !bus_wr && (sel_reg == VEC_REG);

        gpio_port #(.PINS(PINS_P)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_sync (pin_sync[8*p +: 8]),
            .wr_en    (wr_en_p),
            .wr_sel   (sel_reg),
            .wdata    (bus_wdata[8*p +: 8]),
            .vec_clr  (vec_clr_p),
            .in_q     (in_b[p]),
            .out_q    (out_b[p]),
            .dir_q    (dir_b[p]),
            .pull_q   (pull_b[p]),
            .edge_q   (edge_b[p]),
            .ie_q     (ie_b[p]),
            .flag_q   (flag_b[p]),
            .vec      (vec_b[p]),
            .irq      (irq_b[p])
        );

        assign pad_out[8*p +: 8]     = out_b[p];
        assign pad_oe[8*p +: 8]      = dir_b[p];
        assign pad_pull_en[8*p +: 8] = pull_b[p] & ~dir_b[p];
        assign pad_pull_up[8*p +: 8] = pull_b[p] & ~dir_b[p] & out_b[p];
    end

    assign irq       = irq_b;
    assign hi_flag_q = flag_b[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (take && !bus_wr) begin
            case (sel_reg)
                REG_IN:     rdata_q <= {in_b[1],   in_b[0]};
                REG_OUT:    rdata_q <= {out_b[1],  out_b[0]};
                REG_DIR:    rdata_q <= {dir_b[1],  dir_b[0]};
                REG_PULL:   rdata_q <= {pull_b[1], pull_b[0]};
                REG_EDGE:   rdata_q <= {edge_b[1], edge_b[0]};
                REG_IE:     rdata_q <= {ie_b[1],   ie_b[0]};
                REG_FLAG:   rdata_q <= {flag_b[1], flag_b[0]};
                REG_VEC_LO: rdata_q <= {8'h00, vec_b[0]};
                REG_VEC_HI: rdata_q <= {8'h00, vec_b[1]};
                default:    rdata_q <= '0;
            endcase
        end
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/gpio_pair_irq_chk.sv
module gpio_pair_irq_chk #(
    parameter int LO_PINS = 8,
    parameter int HI_PINS = 6
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_wr,
    input logic [3:0]  bus_addr,
    input logic [1:0]  bus_be,
    input logic [15:0] bus_wdata,
    input logic        bus_ready,
    input logic [15:0] pad_out,
    input logic [15:0] pad_oe,
    input logic [15:0] pad_pull_en,
    input logic [1:0]  irq,
    input logic [7:0]  hi_flag_q
);
    localparam logic [7:0] LO_MASK = (LO_PINS >= 8) ? 8'hFF : 8'((1 << LO_PINS) - 1);
    localparam logic [7:0] HI_MASK = (HI_PINS >= 8) ? 8'hFF : 8'((1 << HI_PINS) - 1);

    assert_ready_follows_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_ready) |=> bus_ready);

    assert_ready_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

    assert_pull_input_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pull_en & pad_oe) == 16'h0000);

    assert_low_lane_keeps_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_ready && bus_wr && bus_be == 2'b01) |=> $stable(pad_out[15:8]) && $stable(pad_oe[15:8]));

    assert_dir_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_ready && bus_wr && bus_be[0] && bus_addr == 4'd2)
        |=> pad_oe[7:0] == ($past(bus_wdata[7:0]) & LO_MASK));

    assert_unused_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((hi_flag_q & ~HI_MASK) == 8'h00) && ((pad_out[15:8] & ~HI_MASK) == 8'h00));

    assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_flag_q == 8'h00) |-> !irq[1]);
endmodule

bind gpio_pair_irq gpio_pair_irq_chk #(.LO_PINS(LO_PINS), .HI_PINS(HI_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pull_en (pad_pull_en),
    .irq       (irq),
    .hi_flag_q (hi_flag_q)
);

// File: tb/gpio_pair_irq_test.sv
module gpio_pair_irq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_ready;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out, pad_oe, pad_pull_en, pad_pull_up;
    logic [1:0]  irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    gpio_pair_irq uut (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d, output logic rdy);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = 2'b11;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
        rdy = bus_ready;
        @(negedge clk);
        rdy = rdy & ~bus_ready;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] d; logic r;
        chk("R1 reset oe", pad_oe, 16'h0000);
        chk("R6 reset irq", {14'h0, irq}, 16'h0000);
        rd(4'd1, d, r);
        chk("R13 ready pulse", {15'h0, r}, 16'h0001);
        chk("R1 reset out", d, 16'h0000);
    endtask

    task automatic t_lanes();
        wr(4'd1, 2'b11, 16'h1234);
        chk("R4 half-word write", pad_out, 16'h1234);
        wr(4'd1, 2'b10, 16'hFFAA);
        chk("R4 high byte only, R11 mask", pad_out, 16'h3F34);
        wr(4'd1, 2'b01, 16'h0099);
        chk("R4 low byte only", pad_out, 16'h3F99);
        wr(4'd2, 2'b01, 16'hFFF0);
        chk("R1 direction", pad_oe, 16'h00F0);
    endtask

    task automatic t_pull();
        wr(4'd2, 2'b11, 16'h00FF);
        wr(4'd3, 2'b11, 16'hFFFF);
        chk("R3 pull enable", pad_pull_en, 16'h3F00);
        chk("R3 pull up", pad_pull_up, 16'h3F00);
        wr(4'd1, 2'b10, 16'h0500);
        chk("R3 pull down mix", pad_pull_up, 16'h0500);
    endtask

    task automatic t_input();
        logic [15:0] d; logic r;
        pad_in = 16'hA53C;
        settle();
        rd(4'd0, d, r);
        chk("R2 input sync", d, 16'h253C);
        wr(4'd0, 2'b11, 16'h0000);
        rd(4'd0, d, r);
        chk("R2 input write ignored", d, 16'h253C);
        pad_in = 16'h0000;
        settle();
        wr(4'd6, 2'b11, 16'h0000);
    endtask

    task automatic t_edges();
        logic [15:0] d; logic r;
        wr(4'd4, 2'b11, 16'h0002);
        pad_in[0] = 1'b1; settle();
        pad_in[1] = 1'b1; settle();
        rd(4'd6, d, r);
        chk("R5 rising flag, falling not yet", d, 16'h0001);
        pad_in[1] = 1'b0; settle();
        rd(4'd6, d, r);
        chk("R5 falling flag with IE off", d, 16'h0003);
        chk("R6 no irq without enable", {14'h0, irq}, 16'h0000);
        wr(4'd6, 2'b11, 16'h0000);
        rd(4'd6, d, r);
        chk("R10 flag clear by write", d, 16'h0000);
        pad_in[0] = 1'b0; settle();
        wr(4'd6, 2'b11, 16'h0000);
    endtask

    task automatic t_vector();
        logic [15:0] d; logic r;
        wr(4'd5, 2'b11, 16'h0028);
        wr(4'd6, 2'b01, 16'h002A);
        chk("R6 irq low port", {14'h0, irq}, 16'h0001);
        rd(4'd7, d, r);
        chk("R7 vector pin3 wins", d, 16'h0008);
        rd(4'd7, d, r);
        chk("R8 next vector pin5", d, 16'h000C);
        rd(4'd7, d, r);
        chk("R7 vector empty", d, 16'h0000);
        rd(4'd6, d, r);
        chk("R8 unenabled flag kept", d, 16'h0002);
        chk("R6 irq drops", {14'h0, irq}, 16'h0000);
        wr(4'd5, 2'b10, 16'h0400);
        wr(4'd6, 2'b10, 16'h0400);
        chk("R6 irq high port", {14'h0, irq}, 16'h0002);
        rd(4'd7, d, r);
        chk("R9 low vector separate", d, 16'h0000);
        rd(4'd8, d, r);
        chk("R9 high vector low byte", d, 16'h0006);
        wr(4'd6, 2'b11, 16'h0000);
        wr(4'd5, 2'b11, 16'h0000);
    endtask

    task automatic t_edge_sel();
        logic [15:0] d; logic r;
        pad_in[2] = 1'b1; settle();
        wr(4'd6, 2'b11, 16'h0000);
        wr(4'd4, 2'b11, 16'h0004);
        settle();
        rd(4'd6, d, r);
        chk("R12 select to falling", d, 16'h0000);
        wr(4'd4, 2'b11, 16'h0000);
        settle();
        rd(4'd6, d, r);
        chk("R12 select to rising", d, 16'h0000);
    endtask

    task automatic t_unused();
        logic [15:0] d; logic r;
        wr(4'd5, 2'b10, 16'hFF00);
        pad_in[15] = 1'b1; settle();
        rd(4'd6, d, r);
        chk("R11 unused pin no flag", d, 16'h0000);
        chk("R11 unused pin no irq", {14'h0, irq}, 16'h0000);
        rd(4'd5, d, r);
        chk("R11 unused enable bits", d, 16'h3F00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lanes();
        t_pull();
        t_input();
        t_edges();
        t_vector();
        t_edge_sel();
        t_unused();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule